// File: doc/BRIEF.md
# Sized Access to Wishbone Byte-Lane Adapter

This block takes one byte-addressed memory request at a time and turns it into a single access on a 32-bit Wishbone master port. A request carries a 28-bit byte address, an access size of one, two or four bytes, a direction and write data. The adapter derives three things from the size and the two low address bits: the word address, the byte-select pattern and the lane shift.

On a write, the adapter moves the data into the enabled byte lanes. On a read, it takes the addressed bytes out of the returned word, right-aligns them and zero-extends them. The bus cycle stays open until the slave acknowledges. In the next cycle the adapter closes the cycle and gives the requester a one-cycle done pulse together with the read result. A new request is taken only while the adapter is idle, and it shows this with a ready output.

Top module: `wbLaneAdapter`

## Requirements
- R1: `wbAdr` equals the request byte address shifted right by two (address bits 27:2) for the whole bus cycle.
- R2: Size code 1 (byte) drives `wbSel` = 1 << addr[1:0] and puts write data bits 7:0 into lane addr[1:0]. All other lanes of `wbDatW` are zero.
- R3: Size code 2 (halfword) drives `wbSel` = 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1. Write data bits 15:0 go into those two lanes. addr[0] has no effect.
- R4: Size code 4 (word), and every other size code, drives `wbSel` = 4'b1111 and passes all 32 write data bits unshifted. addr[1:0] have no effect.
- R5: On a read, `doneRdata` is the returned word shifted right by 8 times the effective byte offset, masked to the access size and zero-extended. The effective offset is addr[1:0] for a byte, {addr[1],0} for a halfword and 0 for a word.
- R6: From the cycle after acceptance, `wbCyc` and `wbStb` stay high until `wbAck` is sampled, whatever the acknowledge delay. `wbAdr`, `wbSel`, `wbWe` and `wbDatW` stay stable over that time.
- R7: In the cycle after `wbAck` is sampled, `wbCyc`, `wbStb` and `wbWe` are low and `doneValid` is high for exactly one cycle. On a write, `doneRdata` is zero.
- R8: `reqReady` is high only while idle. A `reqValid` raised while the adapter is busy starts no bus cycle.
- R9: A synchronous active-high `rst` returns the adapter to idle with `reqReady` high and `wbCyc`, `wbStb`, `wbWe` and `doneValid` low. This holds even in the middle of a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Adapter idle, request taken this cycle if valid |
| reqAddr | input | 28 | Byte address |
| reqSize | input | 3 | Access size: 1, 2, else word |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data, right-aligned |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 32 | Right-aligned, zero-extended read data |
| wbAdr | output | 26 | Wishbone word address |
| wbDatW | output | 32 | Wishbone write data |
| wbDatR | input | 32 | Wishbone read data |
| wbSel | output | 4 | Wishbone byte selects |
| wbWe | output | 1 | Wishbone write enable |
| wbCyc | output | 1 | Wishbone cycle |
| wbStb | output | 1 | Wishbone strobe |
| wbAck | input | 1 | Wishbone acknowledge |

## Verification
Byte accesses are tried at all four offsets with a slave word whose every byte is distinct. A wrong lane, a wrong shift or a missing mask therefore shows up as a different value. Halfword and word accesses are tried both with the ignored low address bits set and clear, which tells correct alignment handling apart from plain address pass-through. Size codes 0, 3 and 7 check that unknown sizes fall back to a word access. Acknowledge delays of zero, one and several cycles, a request held high during a busy cycle and a reset in the middle of a cycle check the handshake.

// File: rtl/wbLanePkg.sv
package wbLanePkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef struct packed {
    logic capture;    // take a new request into the datapath
    logic latchRead;  // slave acknowledged: register the result
    logic busy;       // bus cycle open
  } ctrlStrobes_t;

  function automatic accSize_e decodeSize(input logic [2:0] code);
    case (code)
      3'd1:    decodeSize = SZ_BYTE;
      3'd2:    decodeSize = SZ_HALF;
      default: decodeSize = SZ_WORD;
    endcase
  endfunction

endpackage

// File: rtl/wbLaneCtrl.sv
module wbLaneCtrl
  import wbLanePkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         wbAck,
  output logic         reqReady,
  output logic         wbCyc,
  output logic         wbStb,
  output logic         doneValid,
  output ctrlStrobes_t strobes
);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} ctrlState_e;

  ctrlState_e state;
  ctrlState_e stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_BUSY;
      ST_BUSY: if (wbAck)    stateNext = ST_DONE;
      ST_DONE:               stateNext = ST_IDLE;
      default:               stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign reqReady  = (state == ST_IDLE);
  assign wbCyc     = (state == ST_BUSY);
  assign wbStb     = (state == ST_BUSY);
  assign doneValid = (state == ST_DONE);

  always_comb begin
    strobes           = '0;
    strobes.capture   = (state == ST_IDLE) && reqValid;
    strobes.latchRead = (state == ST_BUSY) && wbAck;
    strobes.busy      = (state == ST_BUSY);
  end

  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && !wbAck) |=> (wbCyc && wbStb)); // R6

  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbAck) |=> (!wbCyc && !wbStb && doneValid)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (!wbCyc && !doneValid)); // R8

  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (reqReady && reqValid) |=> wbCyc); // R8

endmodule

// File: rtl/wbLaneDatapath.sv
module wbLaneDatapath
  import wbLanePkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
)(
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobes_t              strobes,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [2:0]                reqSize,
  input  logic                      reqWrite,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [DATA_W-1:0]         wbDatR,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] wbAdr,
  output logic [DATA_W-1:0]         wbDatW,
  output logic [DATA_W/8-1:0]       wbSel,
  output logic                      wbWe,
  output logic [DATA_W-1:0]         doneRdata
);

  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int WADR_W = ADDR_W - OFF_W;

  // ---------------- request decode ----------------
  accSize_e          kindIn;
  logic [OFF_W-1:0]  effOffIn;
  logic [LANES-1:0]  laneMaskIn;
  logic [LANES-1:0]  selIn;
  logic [DATA_W-1:0] shiftedW;
  logic [DATA_W-1:0] alignedW;

  always_comb begin
    kindIn = decodeSize(reqSize);
    case (kindIn)
      SZ_BYTE: begin
        effOffIn   = reqAddr[OFF_W-1:0];
        laneMaskIn = LANES'(1);
      end
      SZ_HALF: begin
        effOffIn   = {reqAddr[OFF_W-1:1], 1'b0};
        laneMaskIn = LANES'(3);
      end
      default: begin
        effOffIn   = '0;
        laneMaskIn = '1;
      end
    endcase
    selIn    = laneMaskIn << effOffIn;
    shiftedW = reqWdata << {effOffIn, 3'b000};
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gWriteLane
    assign alignedW[8*lane +: 8] = selIn[lane] ? shiftedW[8*lane +: 8] : 8'h00;
  end

  // ---------------- captured request ----------------
  accSize_e          kindQ;
  logic [OFF_W-1:0]  effOffQ;
  logic              weQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbAdr   <= '0;
      wbSel   <= '0;
      wbDatW  <= '0;
      weQ     <= 1'b0;
      kindQ   <= SZ_WORD;
      effOffQ <= '0;
    end else if (strobes.capture) begin
      wbAdr   <= reqAddr[ADDR_W-1:OFF_W];
      wbSel   <= selIn;
      wbDatW  <= alignedW;
      weQ     <= reqWrite;
      kindQ   <= kindIn;
      effOffQ <= effOffIn;
    end
  end

  assign wbWe = weQ && strobes.busy;

  // ---------------- read extraction ----------------
  logic [DATA_W-1:0] rdShifted;
  logic [DATA_W-1:0] rdExtract;
  int unsigned       keepBytes;

  always_comb begin
    rdShifted = wbDatR >> {effOffQ, 3'b000};
    case (kindQ)
      SZ_BYTE: keepBytes = 1;
      SZ_HALF: keepBytes = 2;
      default: keepBytes = LANES;
    endcase
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gReadLane
    assign rdExtract[8*lane +: 8] = (lane < keepBytes) ? rdShifted[8*lane +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)                    doneRdata <= '0;
    else if (strobes.latchRead) doneRdata <= weQ ? '0 : rdExtract;
  end

  // ---------------- checks ----------------
  logic [DATA_W-1:0] selBits;
  for (genvar lane = 0; lane < LANES; lane++) begin : gSelBits
    assign selBits[8*lane +: 8] = {8{wbSel[lane]}};
  end

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    strobes.busy |=> (!strobes.busy ||
      ($stable(wbAdr) && $stable(wbSel) && $stable(wbDatW) && $stable(wbWe)))); // R6

  AST_SEL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    strobes.busy |-> (wbSel inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                    4'b0011, 4'b1100, 4'b1111})); // R3

  AST_WRITE_LANES: assert property (@(posedge clk) disable iff (rst)
    strobes.busy |-> ((wbDatW & ~selBits) == '0)); // R2

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (strobes.latchRead && kindQ == SZ_BYTE) |=> (doneRdata[DATA_W-1:8] == '0)); // R5

  AST_WRITE_RESULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobes.latchRead && weQ) |=> (doneRdata == '0)); // R7

endmodule

// File: rtl/wbLaneAdapter.sv
module wbLaneAdapter
  import wbLanePkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [2:0]               reqSize,
  input  logic                     reqWrite,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     doneValid,
  output logic [DATA_W-1:0]        doneRdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] wbAdr,
  output logic [DATA_W-1:0]        wbDatW,
  input  logic [DATA_W-1:0]        wbDatR,
  output logic [DATA_W/8-1:0]      wbSel,
  output logic                     wbWe,
  output logic                     wbCyc,
  output logic                     wbStb,
  input  logic                     wbAck
);

  ctrlStrobes_t strobes;

  wbLaneCtrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .wbAck     (wbAck),
    .reqReady  (reqReady),
    .wbCyc     (wbCyc),
    .wbStb     (wbStb),
    .doneValid (doneValid),
    .strobes   (strobes)
  );

  wbLaneDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .wbDatR    (wbDatR),
    .wbAdr     (wbAdr),
    .wbDatW    (wbDatW),
    .wbSel     (wbSel),
    .wbWe      (wbWe),
    .doneRdata (doneRdata)
  );

  AST_WE_ONLY_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wbWe |-> wbCyc); // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (reqReady && !wbCyc && !wbStb && !wbWe && !doneValid)); // R9

endmodule

// File: tb/test_wbLaneAdapter.sv
`timescale 1ns/1ps
module test_wbLaneAdapter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [27:0] reqAddr = '0;
  logic [2:0]  reqSize = 3'd4;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        doneValid;
  logic [31:0] doneRdata;
  logic [25:0] wbAdr;
  logic [31:0] wbDatW;
  logic [31:0] wbDatR = '0;
  logic [3:0]  wbSel;
  logic        wbWe;
  logic        wbCyc;
  logic        wbStb;
  logic        wbAck = 1'b0;

  always #5 clk = ~clk;

  wbLaneAdapter i_wbLaneAdapter (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .doneValid(doneValid), .doneRdata(doneRdata), .wbAdr(wbAdr), .wbDatW(wbDatW),
    .wbDatR(wbDatR), .wbSel(wbSel), .wbWe(wbWe), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbAck(wbAck)
  );

  typedef struct {
    logic [25:0] adr;
    logic [3:0]  sel;
    logic        we;
    logic [31:0] datW;
    logic [31:0] slaveWord;
    logic [31:0] expRd;
    int          delay;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  int checkCount = 0;
  int failCount  = 0;
  int waitCnt    = 0;
  bit finished   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  // Expected values from the requirements (R1..R5)
  function automatic expItem_t model(input logic [27:0] addr, input logic [2:0] size,
                                     input logic we, input logic [31:0] wdata,
                                     input logic [31:0] slaveWord, input int delay,
                                     input string req);
    expItem_t it;
    int nBytes;
    int off;
    logic [31:0] mask;
    nBytes = (size == 3'd1) ? 1 : (size == 3'd2) ? 2 : 4;
    off    = (nBytes == 1) ? int'(addr[1:0]) : (nBytes == 2) ? 2 * int'(addr[1]) : 0;
    mask   = (nBytes == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nBytes)) - 1);
    it.adr       = addr[27:2];
    it.sel       = 4'(((1 << nBytes) - 1) << off);
    it.we        = we;
    it.datW      = (wdata & mask) << (8 * off);
    it.slaveWord = slaveWord;
    it.expRd     = we ? 32'h0 : ((slaveWord >> (8 * off)) & mask);
    it.delay     = delay;
    it.req       = req;
    return it;
  endfunction

  // Driver: pushes the expected item, issues the request, waits for idle
  task automatic doReq(input logic [27:0] addr, input logic [2:0] size, input logic we,
                       input logic [31:0] wdata, input logic [31:0] slaveWord,
                       input int delay, input string req, input bit pokeBusy = 1'b0);
    do begin @(posedge clk); #2; end while (!reqReady);
    expQ.push_back(model(addr, size, we, wdata, slaveWord, delay, req));
    reqAddr = addr; reqSize = size; reqWrite = we; reqWdata = wdata; reqValid = 1'b1;
    @(posedge clk); #2;
    if (pokeBusy) begin
      // R8: request raised while busy must not start another cycle
      reqAddr = 28'h0ABCDE4; reqSize = 3'd1; reqWrite = 1'b1; reqWdata = 32'h55;
      check(!reqReady, "R8", "ready while busy", 32'(reqReady), 32'h0);
      @(posedge clk); #2;
      check(!reqReady, "R8", "ready while busy", 32'(reqReady), 32'h0);
      @(posedge clk); #2;
    end
    reqValid = 1'b0;
    do begin @(posedge clk); #2; end while (!reqReady);
    @(posedge clk); #2;
    @(posedge clk); #2;
    check(expQ.size() == 0, req, "queue drained", 32'(expQ.size()), 32'h0);
    check(!wbCyc, "R8", "no extra cycle", 32'(wbCyc), 32'h0);
  endtask

  // Slave model and monitor: pops and compares as the design acts
  bit expectDone = 1'b0;
  bit pulseCheck = 1'b0;
  expItem_t doneItem;

  initial begin
    forever begin
      @(negedge clk);
      wbAck = 1'b0;
      if (rst) begin
        expectDone = 1'b0;
        pulseCheck = 1'b0;
      end else if (wbCyc) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected bus cycle", 32'(wbCyc), 32'h0);
          wbDatR = '0;
          wbAck  = 1'b1;
        end else begin
          expItem_t it;
          it = expQ[0];
          check(wbAdr == it.adr, "R1", {it.req, " wbAdr"}, 32'(wbAdr), 32'(it.adr));
          check(wbSel == it.sel, it.req, "wbSel", 32'(wbSel), 32'(it.sel));
          check(wbWe == it.we && wbStb, "R6", "we/stb held", {30'b0, wbStb, wbWe}, {30'b0, 1'b1, it.we});
          if (it.we)
            check(wbDatW == it.datW, it.req, "wbDatW", wbDatW, it.datW);
          if (waitCnt >= it.delay) begin
            wbDatR = it.slaveWord;
            wbAck  = 1'b1;
            waitCnt = 0;
            doneItem = it;
            void'(expQ.pop_front());
            expectDone = 1'b1;
          end else begin
            waitCnt++;
          end
        end
      end else if (expectDone) begin
        expectDone = 1'b0;
        check(doneValid, "R7", "done pulse", 32'(doneValid), 32'h1);
        check(!wbStb && !wbWe, "R7", "stb/we low after ack", {30'b0, wbStb, wbWe}, 32'h0);
        check(doneRdata == doneItem.expRd, doneItem.we ? "R7" : "R5",
              {doneItem.req, " doneRdata"}, doneRdata, doneItem.expRd);
        pulseCheck = 1'b1;
      end else if (pulseCheck) begin
        pulseCheck = 1'b0;
        check(!doneValid, "R7", "done one cycle", 32'(doneValid), 32'h0);
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "WATCHDOG", "timeout", 32'h1, 32'h0);
    finishRun();
  end

  localparam logic [31:0] SLAVE_WORD = 32'hA1B2C3D4;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R9: reset state
    check(reqReady && !wbCyc && !wbStb && !wbWe && !doneValid, "R9", "reset state",
          {27'b0, reqReady, wbCyc, wbStb, wbWe, doneValid}, 32'h10);

    // R2: byte writes and reads at every offset
    for (int off = 0; off < 4; off++) begin
      doReq(28'h0001230 + 28'(off), 3'd1, 1'b1, 32'hFFFF_FF5A + 32'(off), SLAVE_WORD, off, "R2");
      doReq(28'h0004560 + 28'(off), 3'd1, 1'b0, 32'h0, SLAVE_WORD, 1, "R5");
    end

    // R3: halfword at both halves, addr[0] set or clear
    for (int off = 0; off < 4; off++) begin
      doReq(28'h0ABC000 + 28'(off), 3'd2, 1'b1, 32'h1234_BEEF, SLAVE_WORD, 0, "R3");
      doReq(28'h0ABC100 + 28'(off), 3'd2, 1'b0, 32'h0, SLAVE_WORD, 2, "R3");
    end

    // R4: word access, low address bits ignored, unknown size codes
    doReq(28'h0000040, 3'd4, 1'b1, 32'hDEAD_BEEF, SLAVE_WORD, 0, "R4");
    doReq(28'h0000043, 3'd4, 1'b1, 32'hCAFE_F00D, SLAVE_WORD, 1, "R4");
    doReq(28'h0000082, 3'd4, 1'b0, 32'h0, 32'h89AB_CDEF, 0, "R4");
    doReq(28'h0000101, 3'd0, 1'b1, 32'h0BAD_CAFE, SLAVE_WORD, 0, "R4");
    doReq(28'h0000203, 3'd3, 1'b0, 32'h0, 32'h7654_3210, 1, "R4");
    doReq(28'h0000302, 3'd7, 1'b1, 32'h1357_9BDF, SLAVE_WORD, 0, "R4");

    // R1: top of the 28-bit address space
    doReq(28'hFFFFFFF, 3'd1, 1'b0, 32'h0, SLAVE_WORD, 0, "R1");
    doReq(28'hFFFFFFC, 3'd4, 1'b1, 32'h0102_0304, SLAVE_WORD, 3, "R1");

    // R6 / R8: long acknowledge delay with request held high while busy
    doReq(28'h0777770, 3'd2, 1'b0, 32'h0, 32'hFACE_B00C, 6, "R6", 1'b1);
    doReq(28'h0777775, 3'd1, 1'b1, 32'h0000_00C3, SLAVE_WORD, 8, "R6", 1'b1);

    // R9: reset in the middle of a bus cycle
    do begin @(posedge clk); #2; end while (!reqReady);
    expQ.push_back(model(28'h0222220, 3'd4, 1'b0, 32'h0, SLAVE_WORD, 50, "R9"));
    reqAddr = 28'h0222220; reqSize = 3'd4; reqWrite = 1'b0; reqValid = 1'b1;
    @(posedge clk); #2;
    reqValid = 1'b0;
    @(posedge clk); #2;
    check(wbCyc, "R9", "cycle open before reset", 32'(wbCyc), 32'h1);
    rst = 1'b1;
    @(posedge clk); #2;
    check(reqReady && !wbCyc && !wbStb && !wbWe && !doneValid, "R9", "mid-cycle reset",
          {27'b0, reqReady, wbCyc, wbStb, wbWe, doneValid}, 32'h10);
    expQ.delete();
    waitCnt = 0;
    rst = 1'b0;

    // Normal operation resumes after reset
    doReq(28'h0333332, 3'd2, 1'b0, 32'h0, SLAVE_WORD, 1, "R9");

    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule